// File: doc/BRIEF.md
# Receive Sequence Integrity Checker

This block screens received frames on one network channel for sequence order. For each frame the MAC side presents a descriptor made of a link identifier and an 8-bit sequence number. The block compares the number with what it last recorded for that link. It then either forwards the descriptor toward a shared output queue or drops it and raises an error event. One instance sits on each redundant channel. The accepted descriptors from both instances merge into one queue, and no channel tag is added.

For every link the block keeps three things: the last sequence number seen, a flag that marks the first frame since the receiver's reset, and a check-enable bit. Configuration writes the check-enable bit through a small write port. A transmitter counts 0, 1, …, 255 and then wraps to 1, so 0 appears only when the transmitter restarts. The receiver accepts the next number or the one after it, which tolerates a single lost frame. A zero is always accepted. The recorded number follows every frame, including dropped ones, so that a stream that jumped can resume.

Top module: `seq_integrity_checker`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `ok_valid` and `err_valid` are 0. Reset marks every link as awaiting its first frame and turns checking on for every link.
- R2: A frame whose number equals the link's recorded number plus one is accepted. The successor of 255 is 1, and the successor of 0 is 1.
- R3: A frame whose number equals the successor of the successor of the recorded number is accepted. From 254 that is 1, and from 255 that is 2.
- R4: On a checked link, any frame not accepted by R2, R3, R5 or R6 is dropped: `err_valid` pulses with the frame's link and number, and `ok_valid` stays 0.
- R5: A frame with sequence number 0 is always accepted.
- R6: The first frame on a link after reset is accepted whatever its number.
- R7: After every frame, accepted or dropped, the link's recorded number becomes that frame's number and its first-frame mark is cleared.
- R8: Writing `cfg_chk`=0 to a link through `cfg_we`/`cfg_link` makes every later frame on that link pass, and R7 still applies. Writing 1 turns checking back on. A frame in the same cycle as the write sees the old setting.
- R9: Each input frame gives exactly one of `ok_valid` or `err_valid` one cycle later, carrying that frame's link and number. A cycle without an input frame gives neither.
- R10: The recorded state of each link is independent of traffic on the other links.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write strobe for a check-enable bit |
| cfg_link | input | LINK_W | Link whose check-enable bit is written |
| cfg_chk | input | 1 | New check-enable value (1 = check) |
| fd_valid | input | 1 | Frame descriptor present |
| fd_link | input | LINK_W | Link identifier of the frame |
| fd_seq | input | 8 | Sequence number of the frame |
| ok_valid | output | 1 | Frame accepted, to shared queue |
| ok_link | output | LINK_W | Link of the accepted frame |
| ok_seq | output | 8 | Number of the accepted frame |
| err_valid | output | 1 | Frame dropped, error event |
| err_link | output | LINK_W | Link of the dropped frame |
| err_seq | output | 8 | Number of the dropped frame |

## Verification
The bench builds the block with four links. With so few links, directed and random traffic keeps coming back to the same link entries. That brings within reach back-to-back frames on one link, first frames arriving after other links already have history, and configuration writes that land in the same cycle as a frame on the same link. Sequence numbers are drawn near the recorded value, so wraps at 254 and 255, repeats and zeros occur often.

// File: rtl/seqchk_pkg.sv
// Shared types and helpers for the sequence integrity checker.
// Assumes 8-bit sequence numbers that wrap from 255 to 1.
package seqchk_pkg;

    localparam int SEQ_W = 8;

    typedef enum logic {
        VERD_DROP = 1'b0,
        VERD_PASS = 1'b1
    } verdict_e;

    // Successor in the transmit order: 255 wraps to 1, zero is skipped.
    function automatic logic [SEQ_W-1:0] seq_succ(input logic [SEQ_W-1:0] s);
        return (s == {SEQ_W{1'b1}}) ? {{(SEQ_W-1){1'b0}}, 1'b1} : s + 1'b1;
    endfunction

endpackage

// File: rtl/seq_link_table.sv
// Per-link state: last recorded number, first-frame mark, check enable.
// Assumes one frame update and one config write per cycle at most.
// Reads are combinational, so a write is visible on the next cycle.
module seq_link_table
    import seqchk_pkg::*;
#(
    parameter int LINKS  = 16,
    parameter int LINK_W = $clog2(LINKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINK_W-1:0] rd_link,
    output logic [SEQ_W-1:0]  rd_prev,
    output logic              rd_first,
    output logic              rd_chk,
    input  logic              wr_en,
    input  logic [LINK_W-1:0] wr_link,
    input  logic [SEQ_W-1:0]  wr_seq,
    input  logic              cfg_we,
    input  logic [LINK_W-1:0] cfg_link,
    input  logic              cfg_chk
);

    logic [SEQ_W-1:0] prev_q [LINKS];
    logic [LINKS-1:0] first_q;
    logic [LINKS-1:0] chk_q;

    // Record the frame's number and clear its first mark; apply config writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LINKS; i++) prev_q[i] <= '0;
            first_q <= '1;
            chk_q   <= '1;
        end else begin
            if (wr_en) begin
                prev_q[wr_link]  <= wr_seq;
                first_q[wr_link] <= 1'b0;
            end
            if (cfg_we) chk_q[cfg_link] <= cfg_chk;
        end
    end

    // Combinational lookup for the link under test.
    always_comb begin
        rd_prev  = prev_q[rd_link];
        rd_first = first_q[rd_link];
        rd_chk   = chk_q[rd_link];
    end

    // R7
    first_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !first_q[$past(wr_link)]);

    // R7
    prev_recorded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> prev_q[$past(wr_link)] == $past(wr_seq));

endmodule

// File: rtl/seq_judge.sv
// Decides pass or drop for one frame from the link's recorded state.
// Pure combinational logic; assumes the state reflects all earlier frames.
module seq_judge
    import seqchk_pkg::*;
(
    input  logic [SEQ_W-1:0] prev,
    input  logic             first,
    input  logic             chk,
    input  logic [SEQ_W-1:0] seq,
    output verdict_e         verdict
);

    logic [SEQ_W-1:0] exp1;
    logic [SEQ_W-1:0] exp2;

    // Apply the acceptance rules in order of precedence.
    always_comb begin
        exp1 = seq_succ(prev);
        exp2 = seq_succ(exp1);
        if (!chk || first || seq == '0 || seq == exp1 || seq == exp2)
            verdict = VERD_PASS;
        else
            verdict = VERD_DROP;
    end

endmodule

// File: rtl/seq_integrity_checker.sv
// Sequence integrity checker for one receive channel.
// Takes one frame descriptor per cycle and reports a registered verdict
// one cycle later on either the pass side or the error side.
module seq_integrity_checker
    import seqchk_pkg::*;
#(
    parameter int LINKS  = 16,
    parameter int LINK_W = $clog2(LINKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [LINK_W-1:0] cfg_link,
    input  logic              cfg_chk,
    input  logic              fd_valid,
    input  logic [LINK_W-1:0] fd_link,
    input  logic [7:0]        fd_seq,
    output logic              ok_valid,
    output logic [LINK_W-1:0] ok_link,
    output logic [7:0]        ok_seq,
    output logic              err_valid,
    output logic [LINK_W-1:0] err_link,
    output logic [7:0]        err_seq
);

    logic [SEQ_W-1:0] t_prev;
    logic             t_first;
    logic             t_chk;
    verdict_e         verdict;

    seq_link_table #(.LINKS(LINKS), .LINK_W(LINK_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_link  (fd_link),
        .rd_prev  (t_prev),
        .rd_first (t_first),
        .rd_chk   (t_chk),
        .wr_en    (fd_valid),
        .wr_link  (fd_link),
        .wr_seq   (fd_seq),
        .cfg_we   (cfg_we),
        .cfg_link (cfg_link),
        .cfg_chk  (cfg_chk)
    );

    seq_judge u_judge (
        .prev    (t_prev),
        .first   (t_first),
        .chk     (t_chk),
        .seq     (fd_seq),
        .verdict (verdict)
    );

    // Register the verdict and the descriptor onto the matching output side.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_valid  <= 1'b0;
            ok_link   <= '0;
            ok_seq    <= '0;
            err_valid <= 1'b0;
            err_link  <= '0;
            err_seq   <= '0;
        end else begin
            ok_valid  <= fd_valid && (verdict == VERD_PASS);
            err_valid <= fd_valid && (verdict == VERD_DROP);
            ok_link   <= fd_link;
            ok_seq    <= fd_seq;
            err_link  <= fd_link;
            err_seq   <= fd_seq;
        end
    end

    // R9
    one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_valid && err_valid));

    // R9
    frame_answered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fd_valid |=> (ok_valid || err_valid));

    // R9
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fd_valid |=> !(ok_valid || err_valid));

    // R5
    zero_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fd_valid && fd_seq == 8'd0) |=> ok_valid);

    // R4
    err_carries_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fd_valid) |=> (!err_valid || (err_seq == $past(fd_seq) && err_link == $past(fd_link))));

endmodule

// File: tb/seq_integrity_checker_test.sv
// Bench: behavioural per-link model compared with the outputs every cycle.
module seq_integrity_checker_test;

    localparam int LINKS  = 4;
    localparam int LINK_W = 2;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_we;
    logic [LINK_W-1:0] cfg_link;
    logic              cfg_chk;
    logic              fd_valid;
    logic [LINK_W-1:0] fd_link;
    logic [7:0]        fd_seq;
    logic              ok_valid, err_valid;
    logic [LINK_W-1:0] ok_link, err_link;
    logic [7:0]        ok_seq, err_seq;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    int m_prev  [LINKS];
    bit m_first [LINKS];
    bit m_chk   [LINKS];

    always #2 clk = ~clk;

    seq_integrity_checker #(.LINKS(LINKS), .LINK_W(LINK_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_link(cfg_link), .cfg_chk(cfg_chk),
        .fd_valid(fd_valid), .fd_link(fd_link), .fd_seq(fd_seq),
        .ok_valid(ok_valid), .ok_link(ok_link), .ok_seq(ok_seq),
        .err_valid(err_valid), .err_link(err_link), .err_seq(err_seq)
    );

    function automatic int succ(input int s);
        return (s == 255) ? 1 : s + 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < LINKS; i++) begin
            m_prev[i] = 0; m_first[i] = 1'b1; m_chk[i] = 1'b1;
        end
    endtask

    task automatic check(input string req, input bit eok, input bit eerr,
                         input int elink, input int eseq);
        vectors++;
        if (ok_valid !== eok || err_valid !== eerr ||
            (eok && (ok_link !== elink[LINK_W-1:0] || ok_seq !== eseq[7:0])) ||
            (eerr && (err_link !== elink[LINK_W-1:0] || err_seq !== eseq[7:0]))) begin
            fails++;
            $display("FAIL %s: got ok=%0b err=%0b link=%0d/%0d seq=%0d/%0d, expected ok=%0b err=%0b link=%0d seq=%0d",
                     req, ok_valid, err_valid, ok_link, err_link, ok_seq, err_seq,
                     eok, eerr, elink, eseq);
        end
    endtask

    // Drive one cycle of stimulus at the falling edge, model it, compare after the rising edge.
    task automatic step(input bit v, input int link, input int seq,
                        input bit cw, input int clink, input bit cval);
        bit    pass;
        string req;
        fd_valid = v; fd_link = link[LINK_W-1:0]; fd_seq = seq[7:0];
        cfg_we = cw; cfg_link = clink[LINK_W-1:0]; cfg_chk = cval;
        pass = 1'b0; req = "R9";
        if (v) begin
            if (!m_chk[link])                 begin pass = 1; req = "R8"; end
            else if (m_first[link])           begin pass = 1; req = "R6"; end
            else if (seq == 0)                begin pass = 1; req = "R5"; end
            else if (seq == succ(m_prev[link])) begin pass = 1; req = "R2"; end
            else if (seq == succ(succ(m_prev[link]))) begin pass = 1; req = "R3"; end
            else                              begin pass = 0; req = "R4/R7"; end
            m_prev[link] = seq; m_first[link] = 1'b0;
        end
        if (cw) m_chk[clink] = cval;
        @(posedge clk); #1;
        check(req, v && pass, v && !pass, link, seq);
        @(negedge clk);
    endtask

    task automatic frame(input int link, input int seq);
        step(1'b1, link, seq, 1'b0, 0, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; fd_valid = 0; fd_link = 0; fd_seq = 0;
        cfg_we = 0; cfg_link = 0; cfg_chk = 0;
        model_reset();
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        check("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        step(1'b0, 0, 0, 1'b0, 0, 1'b0); // R1 first cycle out of reset

        frame(0, 37);   // R6 first frame
        frame(0, 38);   // R2
        frame(0, 40);   // R3
        frame(0, 43);   // R4 drop
        frame(0, 44);   // R7 resume from dropped number
        frame(0, 0);    // R5
        frame(0, 1);    // R2 successor of 0
        frame(1, 254);  // R6 / R10 other link still first
        frame(1, 255);  // R2
        frame(1, 1);    // R2 wrap to 1
        frame(1, 3);    // R3
        frame(1, 3);    // R4 repeat dropped
        frame(1, 0);    // R5 zero while prev nonzero
        frame(2, 255);  // R6
        frame(2, 2);    // R3 wrap from 255
        frame(2, 254);  // R4
        frame(2, 1);    // R3 wrap from 254
        frame(0, 2);    // R10 link 0 untouched by links 1,2
        // R8: disable link 3 while a frame on it sees the old setting
        frame(3, 10);
        step(1'b1, 3, 99, 1'b1, 3, 1'b0); // still checked -> drop
        frame(3, 7);    // R8 pass
        frame(3, 200);  // R8 pass
        step(1'b1, 3, 5, 1'b1, 3, 1'b1);  // old setting: pass
        frame(3, 6);    // R2 from 5 (R7 under disable)
        frame(3, 9);    // R4

        // Random traffic near the recorded values.
        for (int n = 0; n < 3000; n++) begin
            int l, s, r;
            l = $urandom_range(LINKS-1);
            r = $urandom_range(15);
            if (r < 5)       s = succ(m_prev[l]);
            else if (r < 8)  s = succ(succ(m_prev[l]));
            else if (r < 9)  s = 0;
            else if (r < 11) s = (r == 9) ? 254 : 255;
            else             s = (m_prev[l] + $urandom_range(6)) % 256;
            step($urandom_range(4) != 0, l, s, $urandom_range(9) == 0,
                 $urandom_range(LINKS-1), $urandom_range(2) != 0);
        end

        // Second reset: first-frame marks return, checking re-enabled (R1, R6).
        rst_n = 1'b0; model_reset();
        @(posedge clk); #1; check("R1", 0, 0, 0, 0); @(negedge clk);
        rst_n = 1'b1;
        frame(3, 77);   // R6 after reset
        frame(3, 90);   // R4 checking back on (R1)
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule